// File: doc/BRIEF.md
# Sixteen-bit multicycle processor core

This block is a small processor that fetches and executes one 16-bit instruction at a time from a word-addressed memory. It holds sixteen 16-bit general registers, a program counter, an instruction register and a four-bit flag register. Its ALU sets the flags, and conditional branches and conditional calls test them. The core also drives a 256-port input bus and a 256-port output bus. Every instruction takes one fetch cycle and one execute cycle. A call that is taken adds a third cycle to write the return address to the stack.

The opcode sits in bits 15:12. Bits 11:8 hold a register number or a condition code, and bits 7:0 hold either an 8-bit value or two source register numbers. A 16-bit constant is built in two halves: a low-byte load, then a high-byte load. Branch and call targets always come from the address register (r13 by default). The stack pointer (r14 by default) grows toward lower addresses.

The memory is expected to return read data in the same cycle that it sees the address. A write to memory takes effect at the clock edge while the write strobe is high.

Top module: `cpu16_core`

## Requirements
- R1: Instructions are fetched from the word at the PC, and the PC then increases by one. Bits 15:12 are decoded as LD=0, ST=1, LLI=2, LHI=3, IN=4, OUT=5, ADD=6, SUB=7, NAND=8, SHL=9, SHR=A, SHRA=B, BR=C, CALL=D, RET=E, HALT=F. Each instruction takes two cycles (fetch, then execute), and a taken call takes three. At most one of the memory read, memory write, port read and port write strobes is high in any cycle.
- R2: ADD, SUB and NAND write to the register in bits 11:8. The first source is in bits 7:4 and the second in bits 3:0. SUB computes first minus second. Word 0x6918 adds r1 and r8 into r9.
- R3: SHL, SHR and SHRA shift the register in bits 11:8 by one place and write the result back to it. SHL and SHR fill the vacated bit with zero, and SHRA copies the sign bit.
- R4: Every ALU instruction sets Z when the result is zero and S from result bit 15. The C flag is the carry out for ADD, the borrow (first < second, unsigned) for SUB, and the shifted-out bit for shifts. NAND clears C. V is signed overflow for ADD and SUB and is cleared by NAND and the shifts. No other instruction changes the flags.
- R5: LLI writes bits 7:0 into the low byte of the register in bits 11:8 and clears its high byte. LHI writes bits 7:0 into the high byte and keeps the low byte.
- R6: LD and ST use the effective address r13 + zero-extended bits 7:0. LD moves the memory word into the register in bits 11:8, and ST writes that register to memory.
- R7: IN loads the register in bits 11:8 from the input port numbered by bits 7:0. OUT presents that register on the output port numbered by bits 7:0. Each pulses its strobe for one cycle.
- R8: BR tests the condition in bits 11:8: 0 always, 1 Z, 2 S, 3 C, 4 V, any other value never. When the condition holds, BR loads the PC from r13. Otherwise it only advances the PC.
- R9: CALL uses the same conditions. When taken, it decrements r14, stores the address of the next instruction at the new r14, and loads the PC from r13. When not taken, it changes nothing but the PC.
- R10: RET loads the PC from the word at r14 and then increments r14. Bits 11:0 of the RET word are ignored.
- R11: HALT stops fetching. After that, the core makes no memory or port access, and `halted` stays high until reset.
- R12: While reset is held, the PC is RESET_PC, the registers and flags are zero, and the core presents RESET_PC with a read request so that it can fetch first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| io_in_sel | output | 8 | Input port number |
| io_in_data | input | 16 | Input port data |
| io_in_rd | output | 1 | Input port read strobe |
| io_out_sel | output | 8 | Output port number |
| io_out_data | output | 16 | Output port data |
| io_out_we | output | 1 | Output port write strobe |
| halted | output | 1 | Core is stopped |

## Verification
The bench builds the core with its default parameters: reset PC 0, address register r13 and stack pointer r14. With a zero reset PC, the programs sit at the bottom of a 4096-word bench memory. The stack pointer resets to zero, so the first pre-decrement wraps it to the top word of the address space, and the bench can read the pushed return address from that word. Because r13 and r14 are fixed, random programs can keep clear of them. Random ALU, load, store and port traffic therefore runs alongside never-taken branches and calls without ever leaving the code.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int WORD_W = 16;
  localparam int RIDX_W = 4;
  localparam int NREG   = 1 << RIDX_W;
  localparam int IMM_W  = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_LD   = 4'h0, OP_ST   = 4'h1, OP_LLI  = 4'h2, OP_LHI  = 4'h3,
    OP_IN   = 4'h4, OP_OUT  = 4'h5, OP_ADD  = 4'h6, OP_SUB  = 4'h7,
    OP_NAND = 4'h8, OP_SHL  = 4'h9, OP_SHR  = 4'hA, OP_SHRA = 4'hB,
    OP_BR   = 4'hC, OP_CALL = 4'hD, OP_RET  = 4'hE, OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_PUSH, ST_HALT} state_e;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    word_t  res;
    flags_t fl;
  } alu_out_t;

  // Arithmetic for the flagged ALU: result and all four flags.
  function automatic alu_out_t alu_calc(opcode_e op, word_t a, word_t b);
    alu_out_t o;
    logic [WORD_W:0] wide;
    o    = '0;
    wide = '0;
    case (op)
      OP_ADD: begin
        wide    = {1'b0, a} + {1'b0, b};
        o.res   = wide[WORD_W-1:0];
        o.fl.c  = wide[WORD_W];
        o.fl.v  = (a[WORD_W-1] == b[WORD_W-1]) && (o.res[WORD_W-1] != a[WORD_W-1]);
      end
      OP_SUB: begin
        wide    = {1'b0, a} - {1'b0, b};
        o.res   = wide[WORD_W-1:0];
        o.fl.c  = wide[WORD_W];
        o.fl.v  = (a[WORD_W-1] != b[WORD_W-1]) && (o.res[WORD_W-1] != a[WORD_W-1]);
      end
      OP_NAND: o.res = ~(a & b);
      OP_SHL: begin
        o.res  = {a[WORD_W-2:0], 1'b0};
        o.fl.c = a[WORD_W-1];
      end
      OP_SHR: begin
        o.res  = {1'b0, a[WORD_W-1:1]};
        o.fl.c = a[0];
      end
      OP_SHRA: begin
        o.res  = {a[WORD_W-1], a[WORD_W-1:1]};
        o.fl.c = a[0];
      end
      default: o.res = '0;
    endcase
    o.fl.z = (o.res == '0);
    o.fl.s = o.res[WORD_W-1];
    return o;
  endfunction

  function automatic logic is_alu_op(opcode_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NAND) ||
           (op == OP_SHL) || (op == OP_SHR) || (op == OP_SHRA);
  endfunction

  function automatic logic is_three_reg(opcode_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NAND);
  endfunction
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
(
  input  opcode_e op,
  input  word_t   a,
  input  word_t   b,
  output word_t   res,
  output flags_t  fl
);
  alu_out_t o;

  always_comb begin
    o   = alu_calc(op, a, b);
    res = o.res;
    fl  = o.fl;
  end
endmodule

// File: rtl/cpu16_cond.sv
module cpu16_cond
  import cpu16_pkg::*;
(
  input  flags_t     fl,
  input  logic [3:0] code,
  output logic       met
);
  always_comb begin
    case (code)
      4'd0:    met = 1'b1;
      4'd1:    met = fl.z;
      4'd2:    met = fl.s;
      4'd3:    met = fl.c;
      4'd4:    met = fl.v;
      default: met = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int N_RD = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [RIDX_W-1:0]              waddr,
  input  word_t                          wdata,
  input  logic [N_RD-1:0][RIDX_W-1:0]    raddr,
  output logic [N_RD-1:0][WORD_W-1:0]    rdata
);
  word_t regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata[g] = regs[raddr[g]];
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter int          ADDR_REG = 13,
  parameter int          SP_REG   = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  io_in_sel,
  input  logic [15:0] io_in_data,
  output logic        io_in_rd,
  output logic [7:0]  io_out_sel,
  output logic [15:0] io_out_data,
  output logic        io_out_we,
  output logic        halted
);
  localparam int                N_RD   = 5;
  localparam logic [RIDX_W-1:0] AR_IDX = RIDX_W'(ADDR_REG);
  localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(SP_REG);

  // architectural state
  state_e state_q, state_d;
  word_t  pc_q, pc_d;
  word_t  ir_q, ir_d;
  flags_t flags_q, flags_d;

  // decoded fields
  opcode_e            op;
  logic [RIDX_W-1:0]  f_rx, f_rs, f_ra;
  logic [IMM_W-1:0]   imm;

  assign op   = opcode_e'(ir_q[15:12]);
  assign f_rx = ir_q[11:8];
  assign f_rs = ir_q[7:4];
  assign f_ra = ir_q[3:0];
  assign imm  = ir_q[IMM_W-1:0];

  // register file
  logic                        rf_we;
  logic [RIDX_W-1:0]           rf_waddr;
  word_t                       rf_wdata;
  logic [N_RD-1:0][RIDX_W-1:0] rf_raddr;
  logic [N_RD-1:0][WORD_W-1:0] rf_rdata;
  word_t rx_val, rs_val, ra_val, ar_val, sp_val;

  assign rf_raddr[0] = f_rx;
  assign rf_raddr[1] = f_rs;
  assign rf_raddr[2] = f_ra;
  assign rf_raddr[3] = AR_IDX;
  assign rf_raddr[4] = SP_IDX;
  assign rx_val = rf_rdata[0];
  assign rs_val = rf_rdata[1];
  assign ra_val = rf_rdata[2];
  assign ar_val = rf_rdata[3];
  assign sp_val = rf_rdata[4];

  cpu16_regfile #(.N_RD(N_RD)) i_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  // ALU: three-register ops use bits 7:4 as first operand, shifts use bits 11:8
  word_t  alu_a, alu_res;
  flags_t alu_fl;
  assign alu_a = is_three_reg(op) ? rs_val : rx_val;

  cpu16_alu i_alu (
    .op  (op),
    .a   (alu_a),
    .b   (ra_val),
    .res (alu_res),
    .fl  (alu_fl)
  );

  logic cond_ok;
  cpu16_cond i_cond (
    .fl   (flags_q),
    .code (f_rx),
    .met  (cond_ok)
  );

  word_t ea;
  assign ea = ar_val + {{(WORD_W-IMM_W){1'b0}}, imm};

  // named events for the checker
  logic in_exec;
  logic ev_fetch, ev_alu, ev_call_take, ev_push, ev_branch_skip;
  assign in_exec        = (state_q == ST_EXEC);
  assign ev_fetch       = (state_q == ST_FETCH);
  assign ev_alu         = in_exec && is_alu_op(op);
  assign ev_call_take   = in_exec && (op == OP_CALL) && cond_ok;
  assign ev_push        = (state_q == ST_PUSH);
  assign ev_branch_skip = in_exec && (op == OP_BR) && !cond_ok;

  assign io_in_sel   = imm;
  assign io_out_sel  = imm;
  assign io_out_data = rx_val;
  assign halted      = (state_q == ST_HALT);

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    flags_d   = flags_q;
    mem_addr  = pc_q;
    mem_wdata = rx_val;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    io_in_rd  = 1'b0;
    io_out_we = 1'b0;
    rf_we     = 1'b0;
    rf_waddr  = f_rx;
    rf_wdata  = alu_res;
    case (state_q)
      ST_FETCH: begin
        mem_re  = 1'b1;
        ir_d    = mem_rdata;
        pc_d    = pc_q + 16'd1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op)
          OP_LD: begin
            mem_addr = ea;
            mem_re   = 1'b1;
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
          end
          OP_ST: begin
            mem_addr = ea;
            mem_we   = 1'b1;
          end
          OP_LLI: begin
            rf_we    = 1'b1;
            rf_wdata = {{(WORD_W-IMM_W){1'b0}}, imm};
          end
          OP_LHI: begin
            rf_we    = 1'b1;
            rf_wdata = {imm, rx_val[IMM_W-1:0]};
          end
          OP_IN: begin
            io_in_rd = 1'b1;
            rf_we    = 1'b1;
            rf_wdata = io_in_data;
          end
          OP_OUT: io_out_we = 1'b1;
          OP_ADD, OP_SUB, OP_NAND, OP_SHL, OP_SHR, OP_SHRA: begin
            rf_we   = 1'b1;
            flags_d = alu_fl;
          end
          OP_BR: begin
            if (cond_ok) pc_d = ar_val;
          end
          OP_CALL: begin
            if (cond_ok) begin
              rf_we    = 1'b1;
              rf_waddr = SP_IDX;
              rf_wdata = sp_val - 16'd1;
              state_d  = ST_PUSH;
            end
          end
          OP_RET: begin
            mem_addr = sp_val;
            mem_re   = 1'b1;
            pc_d     = mem_rdata;
            rf_we    = 1'b1;
            rf_waddr = SP_IDX;
            rf_wdata = sp_val + 16'd1;
          end
          OP_HALT: state_d = ST_HALT;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_PUSH: begin
        mem_addr  = sp_val;
        mem_we    = 1'b1;
        mem_wdata = pc_q;
        pc_d      = ar_val;
        state_d   = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input state_e state_q,
  input word_t  pc_q,
  input flags_t flags_q,
  input word_t  ar_val,
  input logic   halted,
  input logic   mem_re,
  input logic   mem_we,
  input logic   io_in_rd,
  input logic   io_out_we,
  input logic   ev_fetch,
  input logic   ev_alu,
  input logic   ev_call_take,
  input logic   ev_push,
  input logic   ev_branch_skip
);
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> pc_q == $past(pc_q) + 16'd1);

  a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we, io_in_rd, io_out_we}));

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_alu |=> $stable(flags_q));

  a_r8_skip_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch_skip |=> $stable(pc_q));

  a_r9_push_after_call: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |-> $past(ev_call_take));

  a_r9_push_target: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> pc_q == $past(ar_val));

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_re || mem_we || io_in_rd || io_out_we));
endmodule

bind cpu16_core cpu16_core_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .state_q        (state_q),
  .pc_q           (pc_q),
  .flags_q        (flags_q),
  .ar_val         (ar_val),
  .halted         (halted),
  .mem_re         (mem_re),
  .mem_we         (mem_we),
  .io_in_rd       (io_in_rd),
  .io_out_we      (io_out_we),
  .ev_fetch       (ev_fetch),
  .ev_alu         (ev_alu),
  .ev_call_take   (ev_call_take),
  .ev_push        (ev_push),
  .ev_branch_skip (ev_branch_skip)
);

// File: tb/test_cpu16_core.sv
module test_cpu16_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MEM_N  = 4096;
  localparam int MAXOUT = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, io_in_data, io_out_data;
  logic        mem_we, mem_re, io_in_rd, io_out_we, halted;
  logic [7:0]  io_in_sel, io_out_sel;

  always #10 clk = ~clk;  // 20 ns period

  cpu16_core i_cpu16_core (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .io_in_sel(io_in_sel), .io_in_data(io_in_data), .io_in_rd(io_in_rd),
    .io_out_sel(io_out_sel), .io_out_data(io_out_data), .io_out_we(io_out_we),
    .halted(halted)
  );

  // bench memory and ports
  logic [15:0] mem [MEM_N];
  logic [15:0] img [MEM_N];
  logic        load = 1'b0;

  function automatic logic [15:0] port_val(logic [7:0] p);
    return {p ^ 8'hA5, p + 8'h3C};
  endfunction

  assign mem_rdata  = mem[mem_addr[11:0]];
  assign io_in_data = port_val(io_in_sel);

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
    end
  end

  logic [23:0] got_log [MAXOUT];
  int          got_n;
  always @(negedge clk) begin
    if (!rst_n) got_n <= 0;
    else if (io_out_we) begin
      if (got_n < MAXOUT) got_log[got_n] <= {io_out_sel, io_out_data};
      got_n <= got_n + 1;
    end
  end

  // counters and check helper
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // program builder
  int pc_w;
  task automatic emit(logic [15:0] w);
    img[pc_w[11:0]] = w;
    pc_w++;
  endtask
  function automatic logic [15:0] e3(logic [3:0] op, logic [3:0] x, logic [3:0] s, logic [3:0] a);
    return {op, x, s, a};
  endfunction
  function automatic logic [15:0] ei(logic [3:0] op, logic [3:0] x, logic [7:0] v);
    return {op, x, v};
  endfunction
  task automatic load16(logic [3:0] r, logic [15:0] val);
    emit(ei(4'h2, r, val[7:0]));
    emit(ei(4'h3, r, val[15:8]));
  endtask
  task automatic clear_img();
    for (int i = 0; i < MEM_N; i++) img[i] = 16'h0000;
    pc_w = 0;
  endtask

  // instruction-level reference model
  logic [15:0] m_mem [MEM_N];
  logic [15:0] m_r [16];
  logic [15:0] m_pc;
  logic        m_z, m_s, m_c, m_v, m_halt;
  logic [23:0] exp_log [MAXOUT];
  int          exp_n;

  function automatic logic m_cond(logic [3:0] cc);
    if (cc == 4'd0) return 1'b1;
    if (cc == 4'd1) return m_z;
    if (cc == 4'd2) return m_s;
    if (cc == 4'd3) return m_c;
    if (cc == 4'd4) return m_v;
    return 1'b0;
  endfunction

  task automatic m_alu(logic [3:0] op, logic [15:0] a, logic [15:0] b, output logic [15:0] r);
    int sa, sb, sr;
    int unsigned ua, ub;
    sa = int'($signed(a)); sb = int'($signed(b));
    ua = int'(a); ub = int'(b);
    m_c = 1'b0; m_v = 1'b0;
    case (op)
      4'h6: begin
        r = 16'(ua + ub); m_c = (ua + ub) > 65535;
        sr = sa + sb; m_v = (sr > 32767) || (sr < -32768);
      end
      4'h7: begin
        r = 16'(ua - ub); m_c = ua < ub;
        sr = sa - sb; m_v = (sr > 32767) || (sr < -32768);
      end
      4'h8: r = ~(a & b);
      4'h9: begin r = a << 1; m_c = a[15]; end
      4'hA: begin r = a >> 1; m_c = a[0]; end
      default: begin r = 16'($signed(a) >>> 1); m_c = a[0]; end
    endcase
    m_z = (r == 16'h0000);
    m_s = r[15];
  endtask

  task automatic model_step();
    logic [15:0] ins, ea, res;
    logic [3:0]  op, x, s, a;
    logic [7:0]  v;
    ins = m_mem[m_pc[11:0]];
    m_pc = m_pc + 16'd1;
    op = ins[15:12]; x = ins[11:8]; s = ins[7:4]; a = ins[3:0]; v = ins[7:0];
    ea = m_r[13] + {8'h00, v};
    case (op)
      4'h0: m_r[x] = m_mem[ea[11:0]];
      4'h1: m_mem[ea[11:0]] = m_r[x];
      4'h2: m_r[x] = {8'h00, v};
      4'h3: m_r[x] = {v, m_r[x][7:0]};
      4'h4: m_r[x] = port_val(v);
      4'h5: begin
        if (exp_n < MAXOUT) exp_log[exp_n] = {v, m_r[x]};
        exp_n++;
      end
      4'h6, 4'h7, 4'h8: begin m_alu(op, m_r[s], m_r[a], res); m_r[x] = res; end
      4'h9, 4'hA, 4'hB: begin m_alu(op, m_r[x], 16'h0000, res); m_r[x] = res; end
      4'hC: if (m_cond(x)) m_pc = m_r[13];
      4'hD: if (m_cond(x)) begin
        m_r[14] = m_r[14] - 16'd1;
        m_mem[m_r[14][11:0]] = m_pc;
        m_pc = m_r[13];
      end
      4'hE: begin m_pc = m_mem[m_r[14][11:0]]; m_r[14] = m_r[14] + 16'd1; end
      default: m_halt = 1'b1;
    endcase
  endtask

  // run the image on model and core, compare output logs
  task automatic run_prog(string tag, output int cyc);
    int lim;
    for (int i = 0; i < MEM_N; i++) m_mem[i] = img[i];
    for (int i = 0; i < 16; i++) m_r[i] = 16'h0000;
    m_pc = 16'h0000; m_z = 0; m_s = 0; m_c = 0; m_v = 0; m_halt = 0; exp_n = 0;
    for (int st = 0; st < 5000 && !m_halt; st++) model_step();
    rst_n = 1'b0;
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc = 0; lim = 4000;
    while (!halted && cyc < lim) begin @(negedge clk); cyc++; end
    chk(tag, {31'd0, halted}, 32'd1, "reached halt");
    chk(tag, got_n, exp_n, "output count");
    for (int i = 0; i < exp_n && i < got_n && i < MAXOUT; i++)
      chk(tag, {8'd0, got_log[i]}, {8'd0, exp_log[i]}, $sformatf("output %0d", i));
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int seed;
    seed = $urandom(32'd20240611);
    clear_img();

    // R12: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", {16'd0, mem_addr}, 32'h0000, "reset address");
    chk("R12", {31'd0, mem_re}, 32'd1, "reset read request");
    chk("R12", {29'd0, mem_we, io_out_we, halted}, 32'd0, "reset strobes");

    // R2: three-register ops incl. 0x6918
    clear_img();
    emit(ei(4'h2, 4'd1, 8'd5));
    emit(ei(4'h2, 4'd8, 8'd7));
    emit(16'h6918);
    emit(ei(4'h5, 4'd9, 8'h10));
    emit(e3(4'h7, 4'd3, 4'd1, 4'd8));
    emit(ei(4'h5, 4'd3, 8'h11));
    emit(e3(4'h8, 4'd4, 4'd1, 4'd8));
    emit(ei(4'h5, 4'd4, 8'h12));
    emit(16'hF000);
    run_prog("R2", cyc);
    chk("R2", {8'd0, got_log[0]}, 32'h0010000C, "0x6918 sum");
    chk("R2", {8'd0, got_log[1]}, 32'h0011FFFE, "sub order");
    chk("R2", {8'd0, got_log[2]}, 32'h0012FFFA, "nand");

    // R5 and R1 timing: six instructions, two cycles each
    clear_img();
    emit(ei(4'h2, 4'd2, 8'h34));
    emit(ei(4'h3, 4'd2, 8'h12));
    emit(ei(4'h5, 4'd2, 8'h01));
    emit(ei(4'h2, 4'd2, 8'hAB));
    emit(ei(4'h5, 4'd2, 8'h02));
    emit(16'hF000);
    run_prog("R5", cyc);
    chk("R5", {8'd0, got_log[0]}, 32'h00011234, "high byte load keeps low");
    chk("R5", {8'd0, got_log[1]}, 32'h000200AB, "low byte load clears high");
    chk("R1", cyc, 32'd12, "cycles to halt");

    // R11: stays halted and silent
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R11", {29'd0, halted, mem_re, mem_we}, 32'b100, "halt quiet");
    end

    // R4 R8: flags from each ALU op, then every condition code
    clear_img();
    for (int t = 0; t < 8; t++) begin
      logic [15:0] av, bv;
      logic [3:0]  op;
      case (t)
        0: begin op = 4'h6; av = 16'h7FFF; bv = 16'h0001; end
        1: begin op = 4'h6; av = 16'hFFFF; bv = 16'h0001; end
        2: begin op = 4'h7; av = 16'h0000; bv = 16'h0001; end
        3: begin op = 4'h7; av = 16'h8000; bv = 16'h0001; end
        4: begin op = 4'h9; av = 16'h8000; bv = 16'h0000; end
        5: begin op = 4'hB; av = 16'h8001; bv = 16'h0000; end
        6: begin op = 4'h8; av = 16'hFFFF; bv = 16'hFFFF; end
        default: begin op = 4'hA; av = 16'h0003; bv = 16'h0000; end
      endcase
      load16(4'd1, av);
      load16(4'd2, bv);
      load16(4'd3, av);
      if (op <= 4'h8) emit(e3(op, 4'd3, 4'd1, 4'd2));
      else emit(ei(op, 4'd3, 8'h00));
      emit(ei(4'h5, 4'd3, 8'hF0));
      for (int cc = 0; cc < 6; cc++) begin
        emit(ei(4'h2, 4'd13, 8'(pc_w + 3)));
        emit(ei(4'hC, 4'(cc), 8'h00));
        emit(ei(4'h5, 4'd0, {4'(cc), 4'(t)}));
      end
    end
    emit(16'hF000);
    run_prog("R4 R8", cyc);

    // R9 R10: taken call, return, not-taken call
    clear_img();
    emit(ei(4'h2, 4'd13, 8'h40));
    emit(ei(4'hD, 4'd0, 8'h00));
    emit(ei(4'h5, 4'd5, 8'h30));
    emit(ei(4'h2, 4'd6, 8'h01));
    emit(e3(4'h6, 4'd7, 4'd6, 4'd0));
    emit(ei(4'hD, 4'd1, 8'h00));
    emit(ei(4'h5, 4'd14, 8'h31));
    emit(16'hF000);
    pc_w = 16'h40;
    emit(ei(4'h2, 4'd5, 8'h77));
    emit(ei(4'h5, 4'd5, 8'h20));
    emit(16'hE5A3);
    run_prog("R9 R10", cyc);
    chk("R9", {8'd0, got_log[0]}, 32'h00200077, "subroutine ran");
    chk("R10", {8'd0, got_log[1]}, 32'h00300077, "resumed after call");
    chk("R10", {8'd0, got_log[2]}, 32'h00310000, "stack pointer restored");
    chk("R9", {16'd0, mem[12'hFFF]}, 32'h0002, "pushed return address");

    // R2 R3 R5 R6 R7: random programs with never-taken branches and calls
    for (int p = 0; p < 8; p++) begin
      clear_img();
      for (int i = 0; i < 256; i++) img[12'h800 + i] = 16'($urandom);
      load16(4'd13, 16'h0800);
      for (int i = 0; i < 13; i++) load16(4'(i), 16'($urandom));
      for (int i = 0; i < 60; i++) begin
        logic [3:0] x;
        logic [7:0] v;
        int k;
        k = $urandom_range(0, 13);
        x = 4'($urandom_range(0, 12));
        v = 8'($urandom);
        case (k)
          0: emit(ei(4'h0, x, v));
          1: emit(ei(4'h1, x, v));
          2: emit(ei(4'h2, x, v));
          3: emit(ei(4'h3, x, v));
          4: emit(ei(4'h4, x, v));
          5: emit(ei(4'h5, x, v));
          6, 7, 8: emit(e3(4'(k), x, 4'($urandom), 4'($urandom)));
          9, 10, 11: emit(ei(4'(k), x, v));
          12: emit(ei(4'hC, 4'($urandom_range(5, 15)), v));
          default: emit(ei(4'hD, 4'($urandom_range(5, 15)), v));
        endcase
      end
      for (int i = 0; i < 15; i++) emit(ei(4'h5, 4'(i), 8'(8'hC0 + i)));
      emit(16'hF000);
      run_prog("R2 R3 R5 R6 R7", cyc);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule